// File: doc/BRIEF.md
# Signed Array Multiplier with Mixed-Weight Adder Cells

This block multiplies two N-bit two's complement operands and returns their full 2N-bit two's complement product. The operands go straight into the array without being complemented or sign-extended first. An AND matrix forms every bit product. A carry-save array of full-adder cells then sums them. Each cell obeys one of four weighting rules, so a signal may carry a negative weight as well as a positive one. The bit products that involve exactly one operand sign bit enter the array with negative weight. The final ripple row turns the mixed-weight sum and carry vectors into an ordinary two's complement result.

The array is purely combinational. One output register, which has a synchronous active-high reset, holds the product. The block can therefore sit directly in a clocked datapath. Operands presented before a rising clock edge appear as the product after that edge.

Top module: `signed_array_mul`

## Requirements
- R1: For every pair of N-bit two's complement operands, the output `p`, read as a 2N-bit two's complement number, equals the signed product of `a` and `b`. Nothing is truncated, and the default is N = 5.
- R2: Once `a` and `b` are settled before a rising edge of `clk`, `p` shows their product after that edge. Between edges, `p` keeps the value it captured at the last edge, whatever the operands do.
- R3: While `rst` is high at a rising edge, `p` becomes all zeros at that edge. The first edge after `rst` falls loads the product again.
- R4: When either operand is zero, `p` becomes all zeros at the next edge.
- R5: When both operands are nonzero, bit 2N-1 of `p` equals the XOR of bit N-1 of `a` and bit N-1 of `b`.
- R6: The most negative operand times itself gives +2^(2N-2), which is +256 for N = 5. The result is positive, and the sign bit of `p` is 0.
- R7: For N = 5, these four products come out as follows: 13 × (−5) = −65, (−5) × 13 = −65, 13 × 5 = 65, and (−5) × (−13) = 65.
- R8: The most negative operand times the most positive one gives −2^(N−1)·(2^(N−1)−1), which is −240 for N = 5.
- R9: Multiplying by +1 returns the operand sign-extended to 2N bits. Multiplying by −1 returns its negation, and for the most negative operand that is +2^(N−1), which is +16 for N = 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the product register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears the product register |
| a | input | N | Multiplicand in two's complement |
| b | input | N | Multiplier in two's complement |
| p | output | 2N | Registered product in two's complement |

## Verification
The design has exactly one register between the operands and `p`, so every product is due one rising edge after its operands are applied.

The bench changes the operands on a falling edge. It reads `p` on the next falling edge, which has exactly one rising edge before it. In one case it also reads `p` shortly after changing the operands, to confirm that the old product is still held.

The reset checks work the same way. Clearing is observed one edge after `rst` is sampled high, and reloading one edge after `rst` is sampled low. The bound properties use the same single-edge offset, relating `p` to the operand values from the previous edge.

// File: rtl/smul_pkg.sv
package smul_pkg;

  // Weighting rule of a generalized full adder (X, Y, Z in; C, S out).
  //   CELL_T0 :  2C + S = X + Y + Z   (all positive)
  //   CELL_T1 :  2C - S = X + Y - Z   (Z and S negative)
  //   CELL_T2 : -2C + S = -X - Y + Z  (X, Y and C negative)
  //   CELL_T3 : -2C - S = -X - Y - Z  (all negative)
  typedef enum logic [1:0] {
    CELL_T0,
    CELL_T1,
    CELL_T2,
    CELL_T3
  } cell_kind_e;

endpackage

// File: rtl/smul_gfa_cell.sv
module smul_gfa_cell
  import smul_pkg::*;
#(
  parameter cell_kind_e KIND = CELL_T0
) (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic c,
  output logic s
);

  // The sum bit is parity for every weighting rule.
  assign s = x ^ y ^ z;

  generate
    if (KIND == CELL_T0 || KIND == CELL_T3) begin : g_same_sign
      // All three inputs share one sign: plain majority.
      assign c = (x & y) | (y & z) | (z & x);
    end else begin : g_mixed_sign
      // Z has the opposite sign to X and Y: majority with Z inverted.
      assign c = (x & y) | (y & ~z) | (~z & x);
    end
  endgenerate

endmodule

// File: rtl/smul_pp_matrix.sv
module smul_pp_matrix #(
  parameter int N = 5
) (
  input  logic [N-1:0]         a,
  input  logic [N-1:0]         b,
  output logic [N-1:0][N-1:0]  pp   // pp[j][i] = a[i] & b[j], weight 2^(i+j)
);

  genvar gj;
  generate
    for (gj = 0; gj < N; gj++) begin : g_row
      assign pp[gj] = a & {N{b[gj]}};
    end
  endgenerate

endmodule

// File: rtl/smul_csa_array.sv
module smul_csa_array
  import smul_pkg::*;
#(
  parameter int N = 5,
  localparam int PW = 2 * N
) (
  input  logic [N-1:0][N-1:0] pp,
  output logic [PW-1:0]       prod
);

  // Row j, slot i sits at weight 2^(i+j); its carry moves to weight 2^(i+j+1).
  logic [N-1:0][N-1:0] sum_w;
  logic [N-1:0][N-1:0] cry_w;
  // Negatively weighted ripple borrows of the final row.
  logic [N-1:0]        rip_w;

  genvar gi, gj, gk;
  generate
    // Row 0: the low bits pass straight through. The negative top product
    // is split into a positive sum bit and a negative carry.
    for (gi = 0; gi < N - 1; gi++) begin : g_row0
      assign sum_w[0][gi] = pp[0][gi];
      assign cry_w[0][gi] = 1'b0;
    end
    smul_gfa_cell #(.KIND(CELL_T2)) u_row0_top (
      .x(pp[0][N-1]), .y(1'b0), .z(1'b0),
      .c(cry_w[0][N-1]), .s(sum_w[0][N-1])
    );

    // Middle rows: positive cells, plus one left-edge cell that absorbs the
    // negative product and the negative carry from the row above.
    for (gj = 1; gj < N - 1; gj++) begin : g_mid
      for (gi = 0; gi < N; gi++) begin : g_col
        if (gi < N - 1) begin : g_pos
          smul_gfa_cell #(.KIND(CELL_T0)) u_cell (
            .x(pp[gj][gi]), .y(sum_w[gj-1][gi+1]), .z(cry_w[gj-1][gi]),
            .c(cry_w[gj][gi]), .s(sum_w[gj][gi])
          );
        end else begin : g_edge
          smul_gfa_cell #(.KIND(CELL_T2)) u_cell (
            .x(pp[gj][gi]), .y(cry_w[gj-1][gi]), .z(1'b0),
            .c(cry_w[gj][gi]), .s(sum_w[gj][gi])
          );
        end
      end
    end

    // Bottom row: the products with the multiplier sign bit are negative.
    for (gi = 0; gi < N; gi++) begin : g_bot
      if (gi < N - 1) begin : g_neg_pp
        smul_gfa_cell #(.KIND(CELL_T1)) u_cell (
          .x(sum_w[N-2][gi+1]), .y(cry_w[N-2][gi]), .z(pp[N-1][gi]),
          .c(cry_w[N-1][gi]), .s(sum_w[N-1][gi])
        );
      end else begin : g_corner
        // The sign-by-sign product is positive; the carry from above is negative.
        smul_gfa_cell #(.KIND(CELL_T1)) u_cell (
          .x(pp[N-1][gi]), .y(1'b0), .z(cry_w[N-2][gi]),
          .c(cry_w[N-1][gi]), .s(sum_w[N-1][gi])
        );
      end
    end

    // Low product bits leave the array on its right-hand diagonal.
    assign prod[0] = sum_w[0][0];
    for (gj = 1; gj < N - 1; gj++) begin : g_low
      assign prod[gj] = sum_w[gj][0];
    end

    // Final row. The bottom sums are negative and the bottom carries are
    // positive. Each slot outputs a positive bit and a negative borrow.
    smul_gfa_cell #(.KIND(CELL_T2)) u_fin_lo (
      .x(sum_w[N-1][0]), .y(1'b0), .z(1'b0),
      .c(rip_w[0]), .s(prod[N-1])
    );
    for (gk = 1; gk < N; gk++) begin : g_fin
      smul_gfa_cell #(.KIND(CELL_T2)) u_cell (
        .x(sum_w[N-1][gk]), .y(rip_w[gk-1]), .z(cry_w[N-1][gk-1]),
        .c(rip_w[gk]), .s(prod[N-1+gk])
      );
    end
  endgenerate

  // Top bit is negatively weighted. Its value is the parity of the positive
  // corner carry and the last borrow; the carry beyond 2N bits is dropped.
  assign prod[PW-1] = cry_w[N-1][N-1] ^ rip_w[N-1];

endmodule

// File: rtl/signed_array_mul.sv
module signed_array_mul #(
  parameter int N = 5,
  localparam int PW = 2 * N
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  a,
  input  logic [N-1:0]  b,
  output logic [PW-1:0] p
);

  logic [N-1:0][N-1:0] pp_w;
  logic [PW-1:0]       prod_w;

  smul_pp_matrix #(.N(N)) u_pp (
    .a  (a),
    .b  (b),
    .pp (pp_w)
  );

  smul_csa_array #(.N(N)) u_arr (
    .pp   (pp_w),
    .prod (prod_w)
  );

  always_ff @(posedge clk) begin
    if (rst) p <= '0;
    else     p <= prod_w;
  end

endmodule

// File: rtl/signed_array_mul_chk.sv
module signed_array_mul_chk #(
  parameter int N = 5,
  localparam int PW = 2 * N
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  a,
  input logic [N-1:0]  b,
  input logic [PW-1:0] p
);

  function automatic logic [PW-1:0] ref_mul(input logic [N-1:0] x, input logic [N-1:0] y);
    logic signed [PW-1:0] xs;
    logic signed [PW-1:0] ys;
    xs = {{N{x[N-1]}}, x};
    ys = {{N{y[N-1]}}, y};
    return xs * ys;
  endfunction

  // R1
  product_match_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> p == ref_mul($past(a), $past(b)));

  // R3
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> p == '0);

  // R4
  zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
    (a == '0 || b == '0) |=> p == '0);

  // R5
  sign_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (a != '0 && b != '0) |=> p[PW-1] == ($past(a[N-1]) ^ $past(b[N-1])));

endmodule

bind signed_array_mul signed_array_mul_chk #(.N(N)) u_chk (.*);

// File: tb/signed_array_mul_tb_top.sv
module signed_array_mul_tb_top;

  localparam int N  = 5;
  localparam int PW = 2 * N;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  a;
  logic [N-1:0]  b;
  logic [PW-1:0] p;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  signed_array_mul #(.N(N)) dut_i (
    .clk (clk),
    .rst (rst),
    .a   (a),
    .b   (b),
    .p   (p)
  );

  function automatic int sx(input logic [N-1:0] v);
    return int'($signed(v));
  endfunction

  function automatic int px(input logic [PW-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (a=%0d b=%0d)", tag, got, exp, sx(a), sx(b));
    end
  endtask

  // Present operands on a falling edge; the product is due one rising edge later.
  task automatic apply(input logic [N-1:0] x, input logic [N-1:0] y);
    @(negedge clk);
    a = x;
    b = y;
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1;
    a = 5'd9;
    b = 5'd7;
    repeat (3) @(negedge clk);
    check("R3 reset clear", px(p), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R3 reload after reset", px(p), 63);

    // R7 worked values
    apply(5'd13, 5'b11011); check("R7 13*-5", px(p), -65);
    apply(5'b11011, 5'd13); check("R7 -5*13", px(p), -65);
    apply(5'd13, 5'd5);     check("R7 13*5", px(p), 65);
    apply(5'b11011, 5'b10011); check("R7 -5*-13", px(p), 65);

    // R6 most negative squared, sign bit clear
    apply(5'b10000, 5'b10000);
    check("R6 min*min", px(p), 256);
    check("R6 sign bit", int'(p[PW-1]), 0);

    // R8 most negative times most positive
    apply(5'b10000, 5'b01111); check("R8 min*max", px(p), -240);
    apply(5'b01111, 5'b10000); check("R8 max*min", px(p), -240);

    // R9 identity and negation
    apply(5'b10110, 5'd1);     check("R9 x*1", px(p), -10);
    apply(5'b10000, 5'b11111); check("R9 min*-1", px(p), 16);
    apply(5'd11, 5'b11111);    check("R9 11*-1", px(p), -11);

    // R2 hold between edges, then update after the next rising edge
    apply(5'd3, 5'd3);
    @(negedge clk);
    a = 5'd7;
    b = 5'b11110;
    #1;
    check("R2 hold before edge", px(p), 9);
    @(negedge clk);
    check("R2 update after edge", px(p), -14);

    // R3 reset in mid-run with operands held
    apply(5'd13, 5'd13);
    rst = 1'b1;
    @(negedge clk);
    check("R3 mid-run clear", px(p), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R3 mid-run reload", px(p), 169);

    // R1, R4, R5 exhaustive sweep
    for (int i = 0; i < (1 << N); i++) begin
      for (int j = 0; j < (1 << N); j++) begin
        apply(N'(i), N'(j));
        if (i == 0 || j == 0) begin
          check("R4 zero operand", px(p), 0);
        end else begin
          check("R1 product", px(p), sx(N'(i)) * sx(N'(j)));
          check("R5 sign bit", int'(p[PW-1]), int'(a[N-1] ^ b[N-1]));
        end
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule